// File: doc/BRIEF.md
# Trap-Context Effective Address Mode Resolver

This block chooses how the effective address of a status-exchange, status-push or modify-and-test (word, halfword or byte) instruction is formed. For each instruction it picks either the restricted format or the standard format. It then drives the enables for indexing, indirection and mapping, an enable for the access-protect and write-lock checks, and the reference address after any masking. The address unit sits downstream and uses these signals to carry out the map lookup and the memory access. Neither of those is part of this block.

The main input is whether the instruction is being executed because a trap or interrupt has sent control to the location that holds it. In that event context, indexing is forbidden. The reference address fills the field that would otherwise name an index register. Mapping is then set by the event type and the mapping bit of the processor status, and the protection checks can be switched off. In ordinary program flow, the instruction fields and status bits control addressing in the usual way.

One register stage captures all outputs. Each result appears one clock after its inputs.

Top module: `xtr_resolver`

## Requirements
- R1: `fmt_o` is one-hot, with bit 0 meaning standard format and bit 1 meaning restricted format. While `rst_n` is low, the outputs are: `fmt_o`=2'b01, indexing, indirection and mapping enables 0, `prot_en_o`=1, `addr_o`=0.
- R2: For an exchange-status instruction (class code 0), standard format is selected only when `at_i`=1 and either `in_event_i`=0 or `real_ext_i`=1. Every other combination selects restricted format.
- R3: For an exchange-status instruction in restricted format, indexing is off and indirection follows `ind_req_i`. Mapping follows `map_bit_i`, so the address is real when that bit is 0 and virtual when it is 1.
- R4: A push-status instruction (class code 1) with `in_event_i`=1 selects restricted format with indexing off. Indirection follows `ind_req_i`.
- R5: For a push-status instruction in restricted format, an interrupt (`is_trap_i`=0) never maps. A trap maps exactly when `map_bit_i`=1.
- R6: A modify-and-test instruction (class codes 2, 3, 4) with `in_event_i`=1 and `is_trap_i`=0 selects restricted format with indexing off and `prot_en_o`=0. Mapping is on only when `ctr_i`=4 and `map_bit_i`=1.
- R7: A modify-and-test instruction with `in_event_i`=1 and `is_trap_i`=1 selects restricted format with indexing off and `prot_en_o`=1. Mapping follows `map_bit_i`. When mapping is on, address bits [19:17] are forced to 0; in big-endian word numbering these are bits 12 to 14. All other bits pass through unchanged.
- R8: A push-status or modify-and-test instruction with `in_event_i`=0, and any class code from 5 to 7, selects standard format. In that case indexing, indirection and mapping follow `idx_req_i`, `ind_req_i` and `map_bit_i`, `prot_en_o`=1, and the address passes through unchanged.
- R9: Every output changes only at a rising clock edge. Its value reflects the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cls_i | input | 3 | Instruction class: 0 exchange-status, 1 push-status, 2/3/4 modify-and-test word/half/byte |
| at_i | input | 1 | AT bit of the exchange-status instruction |
| in_event_i | input | 1 | Instruction is in a trap/interrupt location and runs because of that event |
| is_trap_i | input | 1 | 1 = trap, 0 = interrupt |
| ctr_i | input | 3 | Interrupt counter number |
| map_bit_i | input | 1 | Mapping bit of the processor status |
| real_ext_i | input | 1 | Processor status is in real-extended mode |
| idx_req_i | input | 1 | Instruction requests indexing |
| ind_req_i | input | 1 | Instruction requests indirection |
| ref_addr_i | input | 20 | Reference address |
| fmt_o | output | 2 | One-hot format: bit 0 standard, bit 1 restricted |
| idx_en_o | output | 1 | Indexing enable |
| ind_en_o | output | 1 | Indirection enable |
| map_en_o | output | 1 | Mapping enable |
| prot_en_o | output | 1 | Access-protect / write-lock check enable |
| addr_o | output | 20 | Resolved reference address |

## Verification
Each result is due exactly one rising edge after the inputs that produce it. The bench drives a vector on a falling edge and reads every output on the next falling edge, which lies after the single register stage. It compares those outputs against a model that works from the rules above. For one vector, the bench also reads the outputs just before the rising edge, to show that they still hold the previous result. The checker's properties use the same one-edge spacing: each input condition sampled at one edge is related to the outputs at the next edge.

// File: rtl/xtr_pkg.sv
package xtr_pkg;

    typedef enum logic [2:0] {
        CL_XSTAT = 3'd0,
        CL_PUSH  = 3'd1,
        CL_MTW   = 3'd2,
        CL_MTH   = 3'd3,
        CL_MTB   = 3'd4
    } cls_e;

    localparam logic [1:0] FMT_STD = 2'b01;
    localparam logic [1:0] FMT_RES = 2'b10;

    typedef struct packed {
        logic [1:0] fmt;
        logic       idx;
        logic       ind;
        logic       map;
        logic       prot;
        logic       hi_clr;
    } ctl_t;

endpackage

// File: rtl/xtr_fmt_sel.sv
module xtr_fmt_sel
    import xtr_pkg::*;
#(
    parameter int CTR_W   = 3,
    parameter int MAP_CTR = 4
) (
    input  logic [2:0]       cls,
    input  logic             at,
    input  logic             in_event,
    input  logic             is_trap,
    input  logic [CTR_W-1:0] ctr,
    input  logic             map_bit,
    input  logic             real_ext,
    input  logic             idx_req,
    input  logic             ind_req,
    output ctl_t             ctl
);
    localparam logic [CTR_W-1:0] MAP_CTR_V = CTR_W'(MAP_CTR);

    logic is_mt;

    always_comb begin
        is_mt = (cls == CL_MTW) || (cls == CL_MTH) || (cls == CL_MTB);

        ctl.fmt    = FMT_STD;
        ctl.idx    = idx_req;
        ctl.ind    = ind_req;
        ctl.map    = map_bit;
        ctl.prot   = 1'b1;
        ctl.hi_clr = 1'b0;

        if (cls == CL_XSTAT) begin
            if (!at || (in_event && !real_ext)) begin
                ctl.fmt = FMT_RES;
                ctl.idx = 1'b0;
            end
        end else if (in_event && cls == CL_PUSH) begin
            ctl.fmt = FMT_RES;
            ctl.idx = 1'b0;
            ctl.map = is_trap & map_bit;
        end else if (in_event && is_mt) begin
            ctl.fmt = FMT_RES;
            ctl.idx = 1'b0;
            if (is_trap) begin
                ctl.hi_clr = map_bit;
            end else begin
                ctl.map  = map_bit & (ctr == MAP_CTR_V);
                ctl.prot = 1'b0;
            end
        end
    end

endmodule

// File: rtl/xtr_addr_mask.sv
module xtr_addr_mask #(
    parameter int AW     = 20,
    parameter int MASK_W = 3
) (
    input  logic [AW-1:0] addr,
    input  logic          clr,
    output logic [AW-1:0] addr_out
);
    localparam int KEEP_W = AW - MASK_W;

    always_comb begin
        addr_out = addr;
        if (clr) begin
            addr_out = {{MASK_W{1'b0}}, addr[KEEP_W-1:0]};
        end
    end

endmodule

// File: rtl/xtr_resolver.sv
module xtr_resolver
    import xtr_pkg::*;
#(
    parameter int AW      = 20,
    parameter int CTR_W   = 3,
    parameter int MAP_CTR = 4,
    parameter int MASK_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cls_i,
    input  logic             at_i,
    input  logic             in_event_i,
    input  logic             is_trap_i,
    input  logic [CTR_W-1:0] ctr_i,
    input  logic             map_bit_i,
    input  logic             real_ext_i,
    input  logic             idx_req_i,
    input  logic             ind_req_i,
    input  logic [AW-1:0]    ref_addr_i,
    output logic [1:0]       fmt_o,
    output logic             idx_en_o,
    output logic             ind_en_o,
    output logic             map_en_o,
    output logic             prot_en_o,
    output logic [AW-1:0]    addr_o
);
    typedef struct packed {
        logic [1:0]    fmt;
        logic          idx;
        logic          ind;
        logic          map;
        logic          prot;
        logic [AW-1:0] addr;
    } st_t;

    ctl_t          ctl_w;
    logic [AW-1:0] addr_w;
    st_t           st_d, st_q;

    xtr_fmt_sel #(.CTR_W(CTR_W), .MAP_CTR(MAP_CTR)) u_sel (
        .cls      (cls_i),
        .at       (at_i),
        .in_event (in_event_i),
        .is_trap  (is_trap_i),
        .ctr      (ctr_i),
        .map_bit  (map_bit_i),
        .real_ext (real_ext_i),
        .idx_req  (idx_req_i),
        .ind_req  (ind_req_i),
        .ctl      (ctl_w)
    );

    xtr_addr_mask #(.AW(AW), .MASK_W(MASK_W)) u_mask (
        .addr     (ref_addr_i),
        .clr      (ctl_w.hi_clr),
        .addr_out (addr_w)
    );

    always_comb begin
        st_d.fmt  = ctl_w.fmt;
        st_d.idx  = ctl_w.idx;
        st_d.ind  = ctl_w.ind;
        st_d.map  = ctl_w.map;
        st_d.prot = ctl_w.prot;
        st_d.addr = addr_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.fmt  <= FMT_STD;
            st_q.idx  <= 1'b0;
            st_q.ind  <= 1'b0;
            st_q.map  <= 1'b0;
            st_q.prot <= 1'b1;
            st_q.addr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fmt_o     = st_q.fmt;
    assign idx_en_o  = st_q.idx;
    assign ind_en_o  = st_q.ind;
    assign map_en_o  = st_q.map;
    assign prot_en_o = st_q.prot;
    assign addr_o    = st_q.addr;

endmodule

// File: rtl/xtr_resolver_chk.sv
module xtr_resolver_chk #(
    parameter int AW    = 20,
    parameter int CTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cls_i,
    input logic             in_event_i,
    input logic             is_trap_i,
    input logic [CTR_W-1:0] ctr_i,
    input logic             map_bit_i,
    input logic             idx_req_i,
    input logic [1:0]       fmt_o,
    input logic             idx_en_o,
    input logic             map_en_o,
    input logic             prot_en_o,
    input logic [AW-1:0]    addr_o
);
    logic mt_ev;
    assign mt_ev = in_event_i && (cls_i == 3'd2 || cls_i == 3'd3 || cls_i == 3'd4);

    // R1
    fmt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fmt_o) == 1);

    // R4
    push_no_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == 3'd1 && in_event_i) |=> (fmt_o == 2'b10 && !idx_en_o));

    // R5
    push_int_nomap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_i == 3'd1 && in_event_i && !is_trap_i) |=> !map_en_o);

    // R6
    mt_int_noprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_ev && !is_trap_i) |=> (!prot_en_o && !idx_en_o));

    // R6
    mt_int_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_ev && !is_trap_i && ctr_i != CTR_W'(4)) |=> !map_en_o);

    // R7
    mt_trap_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_ev && is_trap_i && map_bit_i) |=> (map_en_o && addr_o[AW-1 -: 3] == 3'b000 && prot_en_o));

    // R8
    normal_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_event_i && cls_i != 3'd0) |=> (idx_en_o == $past(idx_req_i) && fmt_o == 2'b01));

    // R3
    restr_no_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_o[1] |-> !idx_en_o);

endmodule

bind xtr_resolver xtr_resolver_chk #(.AW(AW), .CTR_W(CTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cls_i      (cls_i),
    .in_event_i (in_event_i),
    .is_trap_i  (is_trap_i),
    .ctr_i      (ctr_i),
    .map_bit_i  (map_bit_i),
    .idx_req_i  (idx_req_i),
    .fmt_o      (fmt_o),
    .idx_en_o   (idx_en_o),
    .map_en_o   (map_en_o),
    .prot_en_o  (prot_en_o),
    .addr_o     (addr_o)
);

// File: tb/xtr_resolver_tb_top.sv
module xtr_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cls_i = '0;
    logic        at_i = 0, in_event_i = 0, is_trap_i = 0;
    logic [2:0]  ctr_i = '0;
    logic        map_bit_i = 0, real_ext_i = 0, idx_req_i = 0, ind_req_i = 0;
    logic [19:0] ref_addr_i = '0;
    logic [1:0]  fmt_o;
    logic        idx_en_o, ind_en_o, map_en_o, prot_en_o;
    logic [19:0] addr_o;

    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    xtr_resolver dut_i (.*);

    typedef struct {
        logic [1:0]  fmt;
        logic        idx, ind, map, prot;
        logic [19:0] addr;
        string       tag;
    } exp_t;

    function automatic exp_t model();
        exp_t e;
        e.fmt = 2'b01; e.idx = idx_req_i; e.ind = ind_req_i;
        e.map = map_bit_i; e.prot = 1'b1; e.addr = ref_addr_i; e.tag = "R8";
        if (cls_i == 3'd0) begin
            e.tag = "R2";
            if (at_i == 1'b0 || (in_event_i == 1'b1 && real_ext_i == 1'b0)) begin
                e.fmt = 2'b10; e.idx = 1'b0; e.tag = "R3";
            end
        end else if (in_event_i && cls_i == 3'd1) begin
            e.fmt = 2'b10; e.idx = 1'b0;
            if (is_trap_i) e.tag = "R5";
            else begin e.map = 1'b0; e.tag = "R4"; end
        end else if (in_event_i && cls_i >= 3'd2 && cls_i <= 3'd4) begin
            e.fmt = 2'b10; e.idx = 1'b0;
            if (is_trap_i) begin
                e.tag = "R7";
                if (map_bit_i) e.addr = e.addr & 20'h1FFFF;
            end else begin
                e.tag = "R6"; e.prot = 1'b0;
                e.map = map_bit_i && (ctr_i == 3'd4);
            end
        end
        return e;
    endfunction

    task automatic compare(exp_t e);
        total++;
        if (fmt_o !== e.fmt || idx_en_o !== e.idx || ind_en_o !== e.ind ||
            map_en_o !== e.map || prot_en_o !== e.prot || addr_o !== e.addr) begin
            bad++;
            $display("FAIL %s: got fmt=%b idx=%b ind=%b map=%b prot=%b addr=%h exp fmt=%b idx=%b ind=%b map=%b prot=%b addr=%h",
                     e.tag, fmt_o, idx_en_o, ind_en_o, map_en_o, prot_en_o, addr_o,
                     e.fmt, e.idx, e.ind, e.map, e.prot, e.addr);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic at, ev, tr, input logic [2:0] ct,
                         input logic mb, re, ix, ir, input logic [19:0] a);
        cls_i = c; at_i = at; in_event_i = ev; is_trap_i = tr; ctr_i = ct;
        map_bit_i = mb; real_ext_i = re; idx_req_i = ix; ind_req_i = ir; ref_addr_i = a;
    endtask

    task automatic run(input logic [2:0] c, input logic at, ev, tr, input logic [2:0] ct,
                       input logic mb, re, ix, ir, input logic [19:0] a);
        exp_t e;
        @(negedge clk);
        drive(c, at, ev, tr, ct, mb, re, ix, ir, a);
        e = model();
        @(negedge clk);
        compare(e);
    endtask

    initial begin
        exp_t rst_e, prev, nxt;
        // R1: reset values
        repeat (3) @(negedge clk);
        rst_e.fmt = 2'b01; rst_e.idx = 0; rst_e.ind = 0; rst_e.map = 0;
        rst_e.prot = 1; rst_e.addr = '0; rst_e.tag = "R1";
        drive(3'd2, 1, 1, 0, 3'd1, 1, 0, 1, 1, 20'hFFFFF);
        @(negedge clk);
        compare(rst_e);
        rst_n = 1'b1;

        // R2 / R3: exchange-status cases
        run(3'd0, 1, 0, 0, 0, 1, 0, 1, 1, 20'h12345);
        run(3'd0, 1, 1, 1, 0, 1, 1, 1, 0, 20'h23456);
        run(3'd0, 1, 1, 0, 0, 1, 0, 1, 1, 20'h34567);
        run(3'd0, 0, 0, 0, 0, 0, 0, 1, 1, 20'h45678);
        run(3'd0, 0, 1, 1, 0, 1, 1, 1, 0, 20'hFFFFF);
        // R4 / R5: push-status in event
        run(3'd1, 0, 1, 0, 0, 1, 0, 1, 1, 20'h0ABCD);
        run(3'd1, 0, 1, 1, 0, 1, 0, 1, 0, 20'h0ABCD);
        run(3'd1, 0, 1, 1, 0, 0, 0, 1, 1, 20'h0ABCD);
        // R6: modify-and-test interrupt, counters 4 and others
        run(3'd2, 0, 1, 0, 3'd4, 1, 0, 1, 1, 20'hE1234);
        run(3'd3, 0, 1, 0, 3'd3, 1, 0, 1, 0, 20'hE1234);
        run(3'd4, 0, 1, 0, 3'd4, 0, 0, 0, 1, 20'hE1234);
        // R7: modify-and-test trap, mapped and real
        run(3'd2, 0, 1, 1, 3'd0, 1, 0, 1, 1, 20'hFFFFF);
        run(3'd4, 0, 1, 1, 3'd0, 0, 0, 1, 1, 20'hFFFFF);
        // R8: normal flow and spare class codes
        run(3'd3, 0, 0, 1, 3'd4, 1, 0, 1, 1, 20'hEEEEE);
        run(3'd6, 0, 1, 0, 3'd4, 0, 0, 1, 0, 20'h54321);

        // R9: output holds until the rising edge
        @(negedge clk);
        drive(3'd2, 0, 1, 1, 3'd0, 1, 0, 1, 1, 20'hFFFFF);
        prev = model();
        @(negedge clk);
        compare(prev);
        drive(3'd1, 0, 0, 0, 3'd0, 0, 0, 0, 0, 20'h00001);
        nxt = model();
        #1;
        prev.tag = "R9";
        compare(prev);
        @(negedge clk);
        nxt.tag = "R9";
        compare(nxt);

        // mixed vectors
        for (int i = 0; i < 400; i++) begin
            run(3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 1'($urandom),
                3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 20'($urandom));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule